// File: doc/BRIEF.md
# Redundant Bus Trigger Watchdog

A backup master sits on two or more time-triggered fieldbus channels. The active master sends a cycle trigger on every channel at nearly the same moment, once per elementary cycle. This block receives one pulse per channel each time such a trigger arrives. It keeps a separate timeout for each channel and uses the set of timeouts to tell two faults apart. If one channel goes silent while the others keep receiving triggers, the channel is partitioned. If every channel goes silent, the active master has died.

On a partitioned channel the block raises a sticky per-channel fault flag. It also raises a one-cycle request, and the backup master answers that request by sending a high-priority error message on all channels so that the active master reschedules. On a dead master the block enters takeover mode. From then on it emits a trigger strobe once per elementary cycle, and the first strobe comes when the retransmission window expires. All durations are counted in clock ticks and set by parameters: cycle length, retransmission window, and the largest skew allowed between channels. WINDOW_TICKS must exceed twice SKEW_TICKS.

Top module: `trig_watchdog`

## Requirements
- R1: A synchronous active-high reset clears every fault flag, the request, the takeover signal and the strobe, and returns the block to monitoring mode.
- R2: Each trigger pulse restarts the timeout of its own channel. If a channel gets no pulse for CYCLE_TICKS+WINDOW_TICKS edges while another channel is alive, its fault flag is visible after edge L+CYCLE_TICKS+WINDOW_TICKS+1, where L is the edge that sampled the channel's last pulse.
- R3: `err_req` is high for exactly one cycle, in the same cycle the new fault flag first appears. Channels that fault on the same edge share a single request.
- R4: A fault flag stays set until its `fault_clr` bit is sampled high. The flag is then low after that edge, and the timeout of that channel restarts from that edge.
- R5: If every channel stops receiving pulses within SKEW_TICKS of each other, no fault flag or request is raised. Instead `takeover` rises after edge M+CYCLE_TICKS+WINDOW_TICKS+1, where M is the latest last pulse.
- R6: `takeover` stays high until reset. `trig_strobe` is high in the cycle takeover rises and then exactly every CYCLE_TICKS cycles, and it is never high outside takeover.
- R7: While in takeover, trigger pulses and silent channels raise no new fault flag and no request.
- R8: With triggers every CYCLE_TICKS on all channels and a skew of less than SKEW_TICKS, no flag, request or takeover occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_trig | input | NUM_BUS | One-cycle pulse per channel when a trigger message is received |
| fault_clr | input | NUM_BUS | Software clear of the per-channel fault flag, which also restarts that channel's timeout |
| bus_fault | output | NUM_BUS | Sticky per-channel partition flag |
| err_req | output | 1 | One-cycle request to send the high-priority error message |
| takeover | output | 1 | Backup master now owns trigger generation |
| trig_strobe | output | 1 | One-cycle strobe to issue a trigger on all channels |

## Verification
The assertions assume that trigger pulses on live channels arrive at most CYCLE_TICKS apart. They also assume that a master failure silences every channel within SKEW_TICKS, and that `fault_clr` is used only as a one-cycle strobe. The stimulus gives each channel a fixed random offset below the skew bound inside a common cycle, and it silences channels only at those cycle positions. As a result, single-channel and all-channel losses stay inside these assumptions, and so do simultaneous losses of two channels with equal offsets.

// File: rtl/twd_pkg.sv
package twd_pkg;
  // ticks without a trigger after which a channel counts as silent
  function automatic int expiry_ticks(input int cycle_ticks, input int window_ticks);
    return cycle_ticks + window_ticks;
  endfunction

  // a channel whose count is below this bound has seen a recent trigger
  function automatic int alive_ticks(input int cycle_ticks, input int window_ticks,
                                     input int skew_ticks);
    return cycle_ticks + window_ticks - skew_ticks;
  endfunction

  function automatic int count_width(input int max_count);
    return (max_count < 2) ? 1 : $clog2(max_count + 1);
  endfunction
endpackage

// File: rtl/twd_bus_timer.sv
module twd_bus_timer import twd_pkg::*; #(
  parameter int LIMIT    = 1225000,
  parameter int ALIVE_LT = 1223000
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic rearm,
  output logic expired,
  output logic alive
);
  localparam int CW = count_width(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || trig || rearm) cnt <= '0;
    else if (cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == CW'(LIMIT));
  assign alive   = (cnt < CW'(ALIVE_LT));

  // R2: a received trigger makes the channel live on the next cycle
  a_r2_rearm_live: assert property (@(posedge clk) disable iff (rst)
    trig |=> (alive && !expired));
endmodule

// File: rtl/twd_fault_arbiter.sv
module twd_fault_arbiter #(
  parameter int NUM_BUS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BUS-1:0] expired,
  input  logic [NUM_BUS-1:0] alive,
  input  logic [NUM_BUS-1:0] clr,
  input  logic               tko,
  output logic [NUM_BUS-1:0] fault,
  output logic               req
);
  logic [NUM_BUS-1:0] others_alive;
  logic [NUM_BUS-1:0] new_fault;

  for (genvar i = 0; i < NUM_BUS; i++) begin : g_judge
    assign others_alive[i] = |(alive & ~(NUM_BUS'(1) << i));
    assign new_fault[i] = !tko && expired[i] && others_alive[i] && !fault[i] && !clr[i];

    // R4: a set flag holds while its clear is low
    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      (fault[i] && !clr[i]) |=> fault[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault <= '0;
      req   <= 1'b0;
    end else begin
      fault <= (fault & ~clr) | new_fault;
      req   <= |new_fault;
    end
  end

  // R3: a request always comes with a freshly set flag
  a_r3_req_new_flag: assert property (@(posedge clk) disable iff (rst)
    req |-> |(fault & ~$past(fault)));
  // R7: no request while the block owns the triggers
  a_r7_no_req_tko: assert property (@(posedge clk) disable iff (rst)
    tko |-> !req);
endmodule

// File: rtl/twd_strobe_gen.sv
module twd_strobe_gen import twd_pkg::*; #(
  parameter int CYCLE_TICKS = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic all_expired,
  output logic takeover,
  output logic strobe
);
  localparam int GW = count_width(CYCLE_TICKS - 1);

  logic [GW-1:0] gcnt;
  logic          enter;
  logic          period_end;

  assign enter      = all_expired && !takeover;
  assign period_end = takeover && (gcnt == GW'(CYCLE_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      takeover <= 1'b0;
      strobe   <= 1'b0;
      gcnt     <= '0;
    end else begin
      takeover <= takeover | enter;
      strobe   <= enter | period_end;
      if (enter || period_end) gcnt <= '0;
      else if (takeover) gcnt <= gcnt + 1'b1;
    end
  end

  // R6: takeover holds, strobes only in takeover, first strobe on entry
  a_r6_tko_sticky: assert property (@(posedge clk) disable iff (rst)
    takeover |=> takeover);
  a_r6_strobe_in_tko: assert property (@(posedge clk) disable iff (rst)
    strobe |-> takeover);
  a_r6_first_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(takeover) |-> strobe);
endmodule

// File: rtl/trig_watchdog.sv
module trig_watchdog import twd_pkg::*; #(
  parameter int NUM_BUS      = 2,
  parameter int CYCLE_TICKS  = 1000000,
  parameter int WINDOW_TICKS = 225000,
  parameter int SKEW_TICKS   = 2000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BUS-1:0] bus_trig,
  input  logic [NUM_BUS-1:0] fault_clr,
  output logic [NUM_BUS-1:0] bus_fault,
  output logic               err_req,
  output logic               takeover,
  output logic               trig_strobe
);
  localparam int LIMIT    = expiry_ticks(CYCLE_TICKS, WINDOW_TICKS);
  localparam int ALIVE_LT = alive_ticks(CYCLE_TICKS, WINDOW_TICKS, SKEW_TICKS);

  logic [NUM_BUS-1:0] expired_v;
  logic [NUM_BUS-1:0] alive_v;
  logic               all_expired;

  for (genvar g = 0; g < NUM_BUS; g++) begin : g_timer
    twd_bus_timer #(.LIMIT(LIMIT), .ALIVE_LT(ALIVE_LT)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .trig    (bus_trig[g]),
      .rearm   (fault_clr[g]),
      .expired (expired_v[g]),
      .alive   (alive_v[g])
    );
  end

  assign all_expired = &expired_v;

  twd_fault_arbiter #(.NUM_BUS(NUM_BUS)) u_arbiter (
    .clk     (clk),
    .rst     (rst),
    .expired (expired_v),
    .alive   (alive_v),
    .clr     (fault_clr),
    .tko     (takeover),
    .fault   (bus_fault),
    .req     (err_req)
  );

  twd_strobe_gen #(.CYCLE_TICKS(CYCLE_TICKS)) u_strobe (
    .clk         (clk),
    .rst         (rst),
    .all_expired (all_expired),
    .takeover    (takeover),
    .strobe      (trig_strobe)
  );

  // R5: entering takeover never coincides with a partition request
  a_r5_clean_takeover: assert property (@(posedge clk) disable iff (rst)
    $rose(takeover) |-> (!err_req && $stable(bus_fault)));
endmodule

// File: tb/trig_watchdog_bench.sv
`timescale 1ns/1ps
module trig_watchdog_bench;
  localparam int NB  = 3;
  localparam int CYC = 40;
  localparam int WIN = 10;
  localparam int SKW = 3;
  localparam int LIM = CYC + WIN;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NB-1:0] trig = '0;
  logic [NB-1:0] fclr = '0;
  logic [NB-1:0] bus_fault;
  logic err_req, takeover, trig_strobe;

  always #2.5 clk = ~clk;

  trig_watchdog #(.NUM_BUS(NB), .CYCLE_TICKS(CYC), .WINDOW_TICKS(WIN), .SKEW_TICKS(SKW))
    u_trig_watchdog (
      .clk(clk), .rst(rst), .bus_trig(trig), .fault_clr(fclr),
      .bus_fault(bus_fault), .err_req(err_req), .takeover(takeover),
      .trig_strobe(trig_strobe));

  int n_run = 0, n_bad = 0, stepn = 0;
  int last_trig[NB];
  int offs[NB];
  logic [NB-1:0] live = '0;
  int req_cnt, req_step, stb_cnt, stb_first, stb_last, stb_gap_bad, tko_step;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expiry_step(input int last);
    return last + LIM + 1;
  endfunction

  function automatic int strobe_total(input int first, input int now);
    return (now - first) / CYC + 1;
  endfunction

  task automatic clear_log;
    req_cnt = 0; req_step = -1; stb_cnt = 0; stb_first = -1;
    stb_last = -1; stb_gap_bad = 0; tko_step = -1;
  endtask

  // one clock: drive at negedge, sample at the following negedge
  task automatic tick(input logic [NB-1:0] clr);
    stepn++;
    for (int i = 0; i < NB; i++) begin
      trig[i] = live[i] && ((stepn % CYC) == offs[i]);
      if (trig[i]) last_trig[i] = stepn;
    end
    fclr = clr;
    @(posedge clk);
    @(negedge clk);
    if (err_req) begin req_cnt++; req_step = stepn; end
    if (trig_strobe) begin
      if (stb_cnt > 0 && stepn - stb_last != CYC) stb_gap_bad++;
      if (stb_cnt == 0) stb_first = stepn;
      stb_cnt++;
      stb_last = stepn;
    end
    if (takeover && tko_step < 0) tko_step = stepn;
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) tick('0);
  endtask

  task automatic do_reset;
    rst = 1'b1; live = '0;
    run(3);
    rst = 1'b0;
    for (int i = 0; i < NB; i++) last_trig[i] = stepn;
  endtask

  task automatic random_offsets;
    for (int i = 0; i < NB; i++) offs[i] = $urandom_range(0, SKW - 1);
  endtask

  initial begin
    int b, clr_step, lastmax;
    void'($urandom(32'd424242));
    @(negedge clk);
    do_reset;
    check(bus_fault == '0 && !err_req && !takeover && !trig_strobe, "R1 reset state",
          {bus_fault, err_req, takeover, trig_strobe}, 0);

    // R8: healthy traffic with skew
    random_offsets; live = '1; clear_log;
    run(6 * CYC);
    check(bus_fault == '0, "R8 no flag", bus_fault, 0);
    check(req_cnt == 0 && tko_step == -1, "R8 no request or takeover", req_cnt, 0);

    // R2/R3: random single-channel partitions
    for (int t = 0; t < 4; t++) begin
      b = $urandom_range(0, NB - 1);
      do_reset; random_offsets; live = '1;
      run(2 * CYC + $urandom_range(0, CYC - 1));
      clear_log;
      live[b] = 1'b0;
      run(LIM + CYC);
      check(req_step == expiry_step(last_trig[b]), "R2 fault timing", req_step,
            expiry_step(last_trig[b]));
      check(bus_fault == (NB'(1) << b), "R2 flag on silent channel", bus_fault, NB'(1) << b);
      check(req_cnt == 1, "R3 single request", req_cnt, 1);
      check(tko_step == -1, "R5 no takeover on partition", tko_step, -1);
    end

    // R4: sticky flag, clear restarts the timeout
    run(2 * CYC);
    check(bus_fault[b] == 1'b1 && req_cnt == 1, "R4 flag sticky", bus_fault, NB'(1) << b);
    clear_log;
    tick(NB'(1) << b); clr_step = stepn;
    check(bus_fault[b] == 1'b0, "R4 flag cleared", bus_fault[b], 0);
    run(LIM + 5);
    check(req_step == expiry_step(clr_step) && req_cnt == 1, "R4 re-detect after clear",
          req_step, expiry_step(clr_step));
    live[b] = 1'b1; run(CYC); clear_log;
    tick(NB'(1) << b);
    run(2 * LIM);
    check(bus_fault == '0 && req_cnt == 0, "R4 recovered channel stays clear", bus_fault, 0);

    // R5/R6: master failure
    clear_log; live = '0;
    lastmax = 0;
    for (int i = 0; i < NB; i++) if (last_trig[i] > lastmax) lastmax = last_trig[i];
    run(LIM + 1 + 3 * CYC + 7);
    check(tko_step == expiry_step(lastmax), "R5 takeover timing", tko_step, expiry_step(lastmax));
    check(bus_fault == '0 && req_cnt == 0, "R5 no partition on dead master", req_cnt, 0);
    check(stb_first == tko_step, "R6 first strobe", stb_first, tko_step);
    check(stb_cnt == strobe_total(stb_first, stepn) && stb_gap_bad == 0, "R6 strobe period",
          stb_cnt, strobe_total(stb_first, stepn));

    // R7: triggers on one channel only after takeover are ignored
    req_cnt = 0; live = NB'(1); offs[0] = 0;
    run(2 * LIM);
    live = '0;
    check(takeover && bus_fault == '0 && req_cnt == 0, "R7 ignored in takeover",
          {takeover, bus_fault}, 1 << NB);
    check(stb_gap_bad == 0 && stb_cnt == strobe_total(stb_first, stepn), "R6 takeover sticky",
          stb_cnt, strobe_total(stb_first, stepn));

    // R1: reset leaves takeover
    do_reset; clear_log;
    check(!takeover && !trig_strobe, "R1 reset exits takeover", takeover, 0);
    random_offsets; live = '1;
    run(3 * CYC);
    check(tko_step == -1 && stb_cnt == 0, "R1 monitoring after reset", stb_cnt, 0);

    // R3: two channels lost on the same edge share one request
    offs[0] = 0; offs[1] = 1; offs[2] = 1;
    run(CYC); clear_log;
    live = NB'(1);
    run(LIM + CYC);
    check(req_cnt == 1, "R3 shared request", req_cnt, 1);
    check(bus_fault == 3'b110, "R3 both flags", bus_fault, 3'b110);
    check(req_step == expiry_step(last_trig[1]), "R2 double fault timing", req_step,
          expiry_step(last_trig[1]));

    // R5: remaining channel then dies
    clear_log; live = '0;
    run(LIM + CYC);
    check(tko_step == expiry_step(last_trig[0]), "R5 takeover after partition", tko_step,
          expiry_step(last_trig[0]));
    check(bus_fault == 3'b110 && req_cnt == 0, "R5 flags kept, no request", bus_fault, 3'b110);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", stepn, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule